// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked-Write Aliases

This block is the register and pad-control slice of one general-purpose I/O port. For each pin it holds three control bits: an ownership bit that hands the pin to GPIO control, a drive-enable bit and a drive-level bit. It also brings the pin levels into the clock domain through a short synchronizer chain, so that software can read them as a read-only register. A plain synchronous register bus (address, write strobe, write data, registered read data) reaches every register.

Each writable register can be reached at two addresses. A plain write replaces the whole register. A masked write at the alias address changes only the pins whose select bit is set in the upper byte of the data word. Each selected pin takes its new level from the lower byte. Separate software threads can then update their own pins without a read-modify-write sequence. The pads see a drive-enable and a drive-level vector. A pin is driven only when it is owned by GPIO and enabled for output. Otherwise it is released.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and in the first cycle after release, the ownership, drive-enable and drive-level registers, the read data and the pad drive-enables are all zero.
- R2: A write to a plain address replaces the whole register with write data bits [7:0]. The plain addresses are 0x00 for ownership, 0x10 for drive-enable and 0x20 for drive-level.
- R3: A write to a masked alias updates each pin n whose bit 8+n is 1 to the value of bit n, and leaves every other pin as it was. The aliases are 0x80 for ownership, 0x90 for drive-enable and 0xA0 for drive-level.
- R4: A masked write whose select byte, bits [15:8], is zero changes no register.
- R5: pad_oe_o[n] is 1 exactly when ownership[n] and drive-enable[n] are both 1. pad_out_o[n] equals drive-level[n] while pad_oe_o[n] is 1 and is 0 otherwise.
- R6: The pin levels pass through two synchronizer flops into the input register, readable at 0x30 (and at 0xB0). The read data shows a pin change on the third rising edge after the change.
- R7: Writes to the input register addresses 0x30 and 0xB0 change no register.
- R8: An address that is not one of the eight mapped addresses (the low nibble must be zero and bits [6:4] must be at most 3) reads as zero, and a write to it changes no register.
- R9: Read data is registered. After an edge, it shows the addressed register as it stood before any write on that same edge. A masked alias reads the same value as its plain address.
- R10: If software sets the level first and then raises the enable, the pad drive-enable rises in the same cycle in which the new level is already present on pad_out_o. It never drives the previous level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pins_i | input | 8 | Pin levels from the pads |
| pad_out_o | output | 8 | Level to drive on each pad |
| pad_oe_o | output | 8 | Per-pad drive enable |

## Verification
A register write takes effect on the edge that samples the strobe. The pad vectors follow combinationally, so they are due one edge after the write. The read data for an address is due one edge after that address is presented, and a pin change reaches the read data on the third edge after it. The bench drives inputs on falling edges and checks each result on the falling edge that follows the edge where it is due. For the synchronizer it checks both the edge before the new value and the edge where it appears, so that one flop too many or too few is caught.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register selected by a bus address; region index order is decoded.
    typedef enum logic [2:0] {
        RSEL_OWN  = 3'd0,
        RSEL_DIR  = 3'd1,
        RSEL_LVL  = 3'd2,
        RSEL_PIN  = 3'd3,
        RSEL_NONE = 3'd7
    } rsel_e;

    // Address layout: low nibble zero, region in the bits above, alias in MSB.
    localparam int unsigned REGION_SHIFT = 4;
    localparam int unsigned REGION_COUNT = 4;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output rsel_e             sel_o,
    output logic              masked_o
);
    localparam int unsigned ALIAS_BIT = ADDR_W - 1;
    localparam int unsigned REG_W     = ALIAS_BIT - REGION_SHIFT;

    logic [REGION_SHIFT-1:0] low_nib;
    logic [REG_W-1:0]        region;

    always_comb begin
        low_nib  = addr_i[REGION_SHIFT-1:0];
        region   = addr_i[ALIAS_BIT-1:REGION_SHIFT];
        masked_o = addr_i[ALIAS_BIT];
        sel_o    = RSEL_NONE;
        if (low_nib == '0 && region < REG_W'(REGION_COUNT)) begin
            case (region[1:0])
                2'd0:    sel_o = RSEL_OWN;
                2'd1:    sel_o = RSEL_DIR;
                2'd2:    sel_o = RSEL_LVL;
                default: sel_o = RSEL_PIN;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] pins_i,
    output logic [N_PINS-1:0] sync_o
);
    logic [N_PINS-1:0] stage_d [STAGES];
    logic [N_PINS-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = pins_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

    // R6: the last stage carries what the stage before it held one edge earlier
    a_r6_sync_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  rsel_e             sel_i,
    input  logic              masked_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_PINS-1:0] pin_sync_i,
    output logic [N_PINS-1:0] own_o,
    output logic [N_PINS-1:0] dir_o,
    output logic [N_PINS-1:0] lvl_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [N_PINS-1:0] own;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] lvl;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [N_PINS-1:0] wsel, wval;

    function automatic logic [N_PINS-1:0] apply_write(
        input logic [N_PINS-1:0] cur,
        input logic              is_masked,
        input logic [N_PINS-1:0] sel,
        input logic [N_PINS-1:0] val
    );
        if (is_masked) return (cur & ~sel) | (val & sel);
        return val;
    endfunction

    always_comb begin
        wval  = wdata_i[N_PINS-1:0];
        wsel  = wdata_i[2*N_PINS-1:N_PINS];
        st_d  = st_q;
        // Read path uses the register values from before this edge's write.
        case (sel_i)
            RSEL_OWN: st_d.rdata = DATA_W'(st_q.own);
            RSEL_DIR: st_d.rdata = DATA_W'(st_q.dir);
            RSEL_LVL: st_d.rdata = DATA_W'(st_q.lvl);
            RSEL_PIN: st_d.rdata = DATA_W'(pin_sync_i);
            default:  st_d.rdata = '0;
        endcase
        if (we_i) begin
            case (sel_i)
                RSEL_OWN: st_d.own = apply_write(st_q.own, masked_i, wsel, wval);
                RSEL_DIR: st_d.dir = apply_write(st_q.dir, masked_i, wsel, wval);
                RSEL_LVL: st_d.lvl = apply_write(st_q.lvl, masked_i, wsel, wval);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign own_o   = st_q.own;
    assign dir_o   = st_q.dir;
    assign lvl_o   = st_q.lvl;
    assign rdata_o = st_q.rdata;

    // R1: after an edge in reset every register is clear
    a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> (own_o == '0 && dir_o == '0 && lvl_o == '0 && rdata_o == '0));

    // R3: unselected pins of a masked level write keep their value
    a_r3_masked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && masked_i && sel_i == RSEL_LVL)
        |=> ((lvl_o & ~$past(wsel)) == ($past(lvl_o) & ~$past(wsel))));

    // R3: selected pins of a masked ownership write take the new value
    a_r3_masked_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && masked_i && sel_i == RSEL_OWN)
        |=> ((own_o & $past(wsel)) == ($past(wval) & $past(wsel))));

    // R4: an empty select byte leaves the targeted register untouched
    a_r4_empty_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && masked_i && wsel == '0) |=> ($stable(own_o) && $stable(dir_o) && $stable(lvl_o)));

    // R7/R8: writes to the input register or unmapped space change nothing
    a_r7_readonly_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (sel_i == RSEL_PIN || sel_i == RSEL_NONE))
        |=> ($stable(own_o) && $stable(dir_o) && $stable(lvl_o)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] own_i,
    input  logic [N_PINS-1:0] dir_i,
    input  logic [N_PINS-1:0] lvl_i,
    output logic [N_PINS-1:0] pad_out_o,
    output logic [N_PINS-1:0] pad_oe_o
);
    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_pin
            logic drive;
            always_comb begin
                drive        = own_i[p] & dir_i[p];
                pad_oe_o[p]  = drive;
                pad_out_o[p] = drive & lvl_i[p];
            end
        end
    endgenerate

    // R5: a pin not owned by GPIO is never driven
    a_r5_unowned_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_oe_o & ~own_i) == '0);

    // R5: a released pin shows no level
    a_r5_released_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_out_o & ~pad_oe_o) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned N_PINS      = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [N_PINS-1:0] pins_i,
    output logic [N_PINS-1:0] pad_out_o,
    output logic [N_PINS-1:0] pad_oe_o
);
    rsel_e             sel;
    logic              masked;
    logic [N_PINS-1:0] pin_sync, own, dir, lvl;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i   (bus_addr_i),
        .sel_o    (sel),
        .masked_o (masked)
    );

    gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins_i),
        .sync_o (pin_sync)
    );

    gpio_ctrl_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (bus_we_i),
        .sel_i      (sel),
        .masked_i   (masked),
        .wdata_i    (bus_wdata_i),
        .pin_sync_i (pin_sync),
        .own_o      (own),
        .dir_o      (dir),
        .lvl_o      (lvl),
        .rdata_o    (bus_rdata_o)
    );

    gpio_pad_drive #(.N_PINS(N_PINS)) u_pads (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .own_i     (own),
        .dir_i     (dir),
        .lvl_i     (lvl),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o)
    );

    // R10: enable rising on a pin already at its level drives that level at once
    a_r10_no_stale_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(pad_oe_o[0]) && $stable(lvl[0])) |-> (pad_out_o[0] == lvl[0]));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int N = 8;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  pins = '0;
    logic [N-1:0]  pad_out, pad_oe;

    logic [N-1:0]  m_own = '0, m_dir = '0, m_lvl = '0, m_in = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_port u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pins),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            8'h00, 8'h80: return DW'(m_own);
            8'h10, 8'h90: return DW'(m_dir);
            8'h20, 8'hA0: return DW'(m_lvl);
            8'h30, 8'hB0: return DW'(m_in);
            default:      return '0;
        endcase
    endfunction

    function automatic logic [N-1:0] merge(input logic [N-1:0] cur, input logic [DW-1:0] d);
        return (cur & ~d[15:8]) | (d[7:0] & d[15:8]);
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        case (a)
            8'h00: m_own = d[7:0];
            8'h10: m_dir = d[7:0];
            8'h20: m_lvl = d[7:0];
            8'h80: m_own = merge(m_own, d);
            8'h90: m_dir = merge(m_dir, d);
            8'hA0: m_lvl = merge(m_lvl, d);
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(negedge clk);
        check(req, rdata, exp_read(a));
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_oe"}, DW'(pad_oe), DW'(m_own & m_dir));
        check({req, " pad_out"}, DW'(pad_out), DW'(m_own & m_dir & m_lvl));
    endtask

    task automatic read_all(input string req);
        bus_read(8'h00, req);
        bus_read(8'h10, req);
        bus_read(8'h20, req);
        bus_read(8'h30, req);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

    initial begin
        logic [AW-1:0] addr_list [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h80, 8'h90, 8'hA0, 8'hB0};
        logic [DW-1:0] old;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, '0);
        check("R1 pad_oe in reset", DW'(pad_oe), '0);
        rst_n = 1'b1;
        check("R1 pad_oe after release", DW'(pad_oe), '0);
        read_all("R1 reset value");

        // R2: plain writes replace the register
        bus_write(8'h00, 32'hFFFF_00A5);
        bus_write(8'h10, 32'h0000_0F3C);
        bus_write(8'h20, 32'h1234_5666);
        read_all("R2 plain write");
        check_pads("R5 after plain writes");

        // R3: masked write touches only selected pins
        bus_write(8'hA0, 32'h0000_0F0A);
        bus_read(8'h20, "R3 masked level");
        bus_write(8'h80, 32'h0000_C3FF);
        bus_read(8'h00, "R3 masked own");
        bus_write(8'h90, 32'h0000_8100);
        bus_read(8'h90, "R3 masked dir via alias read R9");
        check_pads("R5 after masked writes");

        // R4: empty select byte changes nothing
        bus_write(8'h80, 32'hFFFF_00FF);
        bus_write(8'hA0, 32'h0000_00FF);
        read_all("R4 empty select");

        // R10: level first, then ownership, then enable on pin 4
        bus_write(8'h00, 32'h0);
        bus_write(8'h10, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'hA0, 32'h0000_1010);
        check("R10 not driven before enable", DW'(pad_oe[4]), 32'd0);
        bus_write(8'h80, 32'h0000_1010);
        check("R10 owned but not enabled", DW'(pad_oe[4]), 32'd0);
        bus_write(8'h90, 32'h0000_1010);
        check("R10 enable rises", DW'(pad_oe[4]), 32'd1);
        check("R10 level already new", DW'(pad_out[4]), 32'd1);
        bus_write(8'h10, 32'h0000_00FF);
        bus_write(8'h20, 32'h0000_00FF);
        check_pads("R5 unowned pins released");

        // R6: synchronizer latency
        @(negedge clk);
        addr = 8'h30; we = 1'b0; old = DW'(m_in); pins = 8'h96;
        @(negedge clk);
        @(negedge clk);
        check("R6 old value after two edges", rdata, old);
        @(negedge clk);
        check("R6 new value on third edge", rdata, 32'h96);
        m_in = 8'h96;

        // R7: input register is read-only
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'hB0, 32'hFFFF_0000);
        read_all("R7 write to input ignored");

        // R8: unmapped addresses
        bus_read(8'h04, "R8 unmapped 0x04");
        bus_read(8'h40, "R8 unmapped 0x40");
        bus_read(8'hF0, "R8 unmapped 0xF0");
        bus_write(8'h44, 32'h0000_FF00);
        bus_write(8'h50, 32'h0000_FFFF);
        read_all("R8 unmapped write ignored");

        // R9: read returns value from before a same-edge write
        @(negedge clk);
        addr = 8'h20; we = 1'b1; wdata = 32'h0000_0033; old = DW'(m_lvl);
        @(negedge clk);
        we = 1'b0;
        check("R9 read before write", rdata, old);
        model_write(8'h20, 32'h0000_0033);
        @(negedge clk);
        check("R9 read after write", rdata, 32'h33);

        // Random mix: R2 R3 R5 R7 R8 R9
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int op;
            op = int'($urandom_range(0, 3));
            a  = (op == 3) ? AW'($urandom) : addr_list[$urandom_range(0, 7)];
            d  = $urandom;
            if (op == 0) bus_read(a, "R9 random read");
            else begin
                bus_write(a, d);
                check_pads("R5 random");
                bus_read(addr_list[$urandom_range(0, 7)], "R3 random readback");
            end
        end

        done = 1;
        report();
    end
endmodule